// File: doc/BRIEF.md
# Combined Legacy/Message Interrupt Status Unit

This unit merges four level-style legacy interrupt lines and one message-interrupt pending flag into a single upstream interrupt request. Every source is captured into a sticky bit of a status word, and each bit is gated by a matching bit of an enable word. The request output is registered and stays high while any captured and enabled bit remains set.

Software reads the status word to find the pending sources. After servicing a source it writes a one to that source's status bit, which clears it. Writing a zero leaves a bit as it is. Each source can be masked or unmasked on its own by clearing or setting its enable bit. Masking hides a source from the request output, but its status bit still records new events.

The register port is a plain single-cycle bus with a word address, a write strobe and write data. Read data follows the address combinationally. The legacy field sits at bits 8:5 of both words, with line k at bit 5+k. The message flag sits at bit 3.

Top module: `isu_top`

## Requirements
- R1: After reset the status word and the enable word both read 0, and `irq_o` is low.
- R2: While legacy line k (k = 0..3) is high at a clock edge, status bit 5+k is set after that edge. It stays set after the line falls, until software clears it.
- R3: While `msi_pend_i` is high at a clock edge, status bit 3 is set after that edge. It stays set until software clears it.
- R4: A write to word address 0 (status) clears every status bit whose write-data bit is 1. Status bits whose write-data bit is 0 keep their value.
- R5: If a source is high in the same cycle that a write-one-to-clear targets its status bit, the bit stays set.
- R6: A write to word address 1 (enable) loads write-data bits 3 and 8:5 into the enable word. All other enable bits read 0.
- R7: `irq_o` is a register. After each clock edge it equals the OR of (status AND enable) as it was before that edge.
- R8: A source whose enable bit is 0 still sets its status bit, but it never raises `irq_o`.
- R9: Word addresses 2 and 3 read 0. Writes to them change neither the status word nor the enable word.
- R10: Status bits other than 3 and 8:5 always read 0. No register write can set a status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| intx_i | input | 4 | Legacy interrupt lines, active high |
| msi_pend_i | input | 1 | Message interrupt pending flag |
| reg_addr_i | input | 2 | Word address: 0 status, 1 enable |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the addressed word |
| irq_o | output | 1 | Combined interrupt request, registered |

## Verification
The bench builds the unit with its default parameters: a 32-bit data word, four legacy lines starting at bit 5, and the message flag at bit 3. With these values the whole set of implemented bits fits in nine bit positions. Random writes of arbitrary data can therefore hit implemented, unimplemented and out-of-range addresses, and random source patterns often line up with clears in the same cycle. Directed cases cover reset, sticky capture, masking, the collision between a new event and a clear, and the unused addresses.

// File: rtl/isu_pkg.sv
package isu_pkg;
  localparam int unsigned ISU_ADDR_W = 2;
  typedef enum logic [ISU_ADDR_W-1:0] {
    ISU_STAT = 2'd0,
    ISU_ENAB = 2'd1
  } isu_reg_e;
endpackage

// File: rtl/isu_src_map.sv
module isu_src_map #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_INTX = 4,
  parameter int unsigned INTX_LSB = 5,
  parameter int unsigned MSI_POS  = 3
) (
  input  logic [NUM_INTX-1:0] intx_i,
  input  logic                msi_pend_i,
  output logic [DATA_W-1:0]   ev_o
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b >= INTX_LSB && b < INTX_LSB + NUM_INTX) begin : g_intx
      assign ev_o[b] = intx_i[b-INTX_LSB];
    end else if (b == MSI_POS) begin : g_msi
      assign ev_o[b] = msi_pend_i;
    end else begin : g_none
      assign ev_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/isu_sticky_bank.sv
module isu_sticky_bank #(
  parameter int unsigned        DATA_W = 32,
  parameter logic [DATA_W-1:0]  IMPL   = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] set_i,
  input  logic [DATA_W-1:0] clr_i,
  output logic [DATA_W-1:0] q_o
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (IMPL[b]) begin : g_ff
      logic q;
      // new event wins over a clear in the same cycle
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b0;
        else         q <= set_i[b] | (q & ~clr_i[b]);
      end
      assign q_o[b] = q;
    end else begin : g_tie
      assign q_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/isu_enable_reg.sv
module isu_enable_reg #(
  parameter int unsigned       DATA_W = 32,
  parameter logic [DATA_W-1:0] IMPL   = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (we_i) q <= wdata_i & IMPL;
  end
  assign q_o = q;
endmodule

// File: rtl/isu_irq_gate.sv
module isu_irq_gate #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] stat_i,
  input  logic [DATA_W-1:0] en_i,
  output logic              irq_o
);
  logic irq_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(stat_i & en_i);
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/isu_top.sv
module isu_top
  import isu_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_INTX = 4,
  parameter int unsigned INTX_LSB = 5,
  parameter int unsigned MSI_POS  = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_INTX-1:0]   intx_i,
  input  logic                  msi_pend_i,
  input  logic [ISU_ADDR_W-1:0] reg_addr_i,
  input  logic                  reg_we_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  output logic                  irq_o
);
  localparam logic [DATA_W-1:0] INTX_FIELD = ((DATA_W'(1) << NUM_INTX) - DATA_W'(1)) << INTX_LSB;
  localparam logic [DATA_W-1:0] IMPL       = INTX_FIELD | (DATA_W'(1) << MSI_POS);

  logic [DATA_W-1:0] ev, stat_q, en_q, clr;
  logic              stat_wr, en_wr;

  assign stat_wr = reg_we_i && (reg_addr_i == ISU_STAT);
  assign en_wr   = reg_we_i && (reg_addr_i == ISU_ENAB);
  assign clr     = stat_wr ? reg_wdata_i : '0;

  isu_src_map #(.DATA_W(DATA_W), .NUM_INTX(NUM_INTX), .INTX_LSB(INTX_LSB), .MSI_POS(MSI_POS)) u_map (
    .intx_i(intx_i), .msi_pend_i(msi_pend_i), .ev_o(ev)
  );

  isu_sticky_bank #(.DATA_W(DATA_W), .IMPL(IMPL)) u_stat (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(ev), .clr_i(clr), .q_o(stat_q)
  );

  isu_enable_reg #(.DATA_W(DATA_W), .IMPL(IMPL)) u_en (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(en_wr), .wdata_i(reg_wdata_i), .q_o(en_q)
  );

  isu_irq_gate #(.DATA_W(DATA_W)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .stat_i(stat_q), .en_i(en_q), .irq_o(irq_o)
  );

  always_comb begin
    unique case (reg_addr_i)
      ISU_STAT: reg_rdata_o = stat_q;
      ISU_ENAB: reg_rdata_o = en_q;
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/isu_checker.sv
module isu_checker #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_INTX = 4,
  parameter int unsigned INTX_LSB = 5,
  parameter int unsigned MSI_POS  = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_INTX-1:0] intx_i,
  input logic                msi_pend_i,
  input logic [1:0]          reg_addr_i,
  input logic                reg_we_i,
  input logic [DATA_W-1:0]   reg_wdata_i,
  input logic                irq_o,
  input logic [DATA_W-1:0]   stat_q,
  input logic [DATA_W-1:0]   en_q
);
  logic [DATA_W-1:0] ev;
  assign ev = (DATA_W'(intx_i) << INTX_LSB) | (DATA_W'(msi_pend_i) << MSI_POS);

  always @(posedge clk_i) begin
    if (!rst_ni) a_r1_reset_quiet: assert (!irq_o);
  end

  a_r2_intx_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|intx_i) |=> ((stat_q[INTX_LSB +: NUM_INTX] & $past(intx_i)) == $past(intx_i)));

  a_r3_msi_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msi_pend_i |=> stat_q[MSI_POS]);

  a_r4_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 2'd0) |=> ((stat_q & $past(reg_wdata_i & ~ev)) == '0));

  a_r5_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ev) |=> ((stat_q & $past(ev)) == $past(ev)));

  a_r7_irq_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(stat_q & en_q)) |=> irq_o);

  a_r7_irq_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(stat_q & en_q)) |=> !irq_o);

  a_r9_unused_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i[1]) |=> ($stable(en_q) && ((stat_q & ~$past(stat_q)) == ($past(ev) & ~$past(stat_q)))));
endmodule

bind isu_top isu_checker #(
  .DATA_W(DATA_W), .NUM_INTX(NUM_INTX), .INTX_LSB(INTX_LSB), .MSI_POS(MSI_POS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .intx_i(intx_i), .msi_pend_i(msi_pend_i),
  .reg_addr_i(reg_addr_i), .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i),
  .irq_o(irq_o), .stat_q(stat_q), .en_q(en_q)
);

// File: tb/tb_isu_top.sv
`timescale 1ns/1ps
module tb_isu_top;
  localparam logic [31:0] IMPL = 32'h0000_01E8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  intx_i = '0;
  logic        msi_pend_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic        reg_we_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int total = 0;
  int bad = 0;
  logic [31:0] m_st = '0;
  logic [31:0] m_en = '0;
  logic        m_irq = 1'b0;

  always #2.5 clk = ~clk;

  isu_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .intx_i(intx_i), .msi_pend_i(msi_pend_i),
    .reg_addr_i(reg_addr_i), .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  function automatic logic [31:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0:    return m_st;
      2'd1:    return m_en;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [3:0] ix, input logic ms, input logic [1:0] a,
                     input logic we, input logic [31:0] wd, input string tag);
    logic [31:0] ev, nst, nen;
    logic        nirq;
    @(negedge clk);
    intx_i = ix; msi_pend_i = ms; reg_addr_i = a; reg_we_i = we; reg_wdata_i = wd;
    #1;
    chk(tag, reg_rdata_o, exp_read(a));
    chk("R7 irq", {31'b0, irq_o}, {31'b0, m_irq});
    ev   = (32'(ix) << 5) | (32'(ms) << 3);
    nst  = (we && a == 2'd0) ? ((m_st & ~wd) | ev) : (m_st | ev);
    nen  = (we && a == 2'd1) ? (wd & IMPL) : m_en;
    nirq = |(m_st & m_en);
    @(posedge clk);
    m_st = nst; m_en = nen; m_irq = nirq;
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 irq in reset", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;

    cyc(4'h0, 1'b0, 2'd0, 1'b0, 32'h0, "R1 status");
    cyc(4'h0, 1'b0, 2'd1, 1'b0, 32'h0, "R1 enable");

    cyc(4'b0101, 1'b0, 2'd0, 1'b0, 32'h0, "R2 read");
    cyc(4'h0, 1'b0, 2'd0, 1'b0, 32'h0, "R2 sticky");
    cyc(4'h0, 1'b1, 2'd0, 1'b0, 32'h0, "R3 read");
    cyc(4'h0, 1'b0, 2'd0, 1'b0, 32'h0, "R3 sticky");
    chk("R2 field", reg_rdata_o & 32'h1E0, 32'h0A0);

    cyc(4'h0, 1'b0, 2'd1, 1'b1, 32'hFFFF_FFFF, "R6 write");
    cyc(4'h0, 1'b0, 2'd1, 1'b0, 32'h0, "R6 read");
    cyc(4'h0, 1'b0, 2'd0, 1'b0, 32'h0, "R7 status");
    chk("R7 asserted", {31'b0, irq_o}, 32'h1);

    cyc(4'h0, 1'b0, 2'd0, 1'b1, 32'h0000_0020, "R4 clear");
    cyc(4'h0, 1'b0, 2'd0, 1'b0, 32'h0, "R4 read");
    cyc(4'b0100, 1'b0, 2'd0, 1'b1, 32'h0000_0080, "R5 collide");
    cyc(4'h0, 1'b0, 2'd0, 1'b0, 32'h0, "R5 read");
    chk("R5 bit7", reg_rdata_o & 32'h80, 32'h80);

    cyc(4'h0, 1'b0, 2'd1, 1'b1, 32'h0, "R8 mask all");
    cyc(4'h0, 1'b0, 2'd0, 1'b1, 32'hFFFF_FFFF, "R10 clear all");
    cyc(4'h0, 1'b0, 2'd0, 1'b0, 32'h0, "R10 read zero");
    cyc(4'b1000, 1'b1, 2'd0, 1'b0, 32'h0, "R8 source");
    cyc(4'h0, 1'b0, 2'd0, 1'b0, 32'h0, "R8 status");
    cyc(4'h0, 1'b0, 2'd0, 1'b0, 32'h0, "R8 status");
    chk("R8 irq low", {31'b0, irq_o}, 32'h0);

    cyc(4'h0, 1'b0, 2'd2, 1'b1, 32'hFFFF_FFFF, "R9 write a2");
    cyc(4'h0, 1'b0, 2'd3, 1'b1, 32'hFFFF_FFFF, "R9 write a3");
    cyc(4'h0, 1'b0, 2'd2, 1'b0, 32'h0, "R9 read a2");
    cyc(4'h0, 1'b0, 2'd0, 1'b0, 32'h0, "R9 status kept");
    cyc(4'h0, 1'b0, 2'd1, 1'b0, 32'h0, "R9 enable kept");

    for (int i = 0; i < 4000; i++) begin
      logic [3:0]  ix;
      logic        ms;
      logic [1:0]  a;
      logic        we;
      logic [31:0] wd;
      ix = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
      ms = ($urandom % 6 == 0);
      a  = 2'($urandom);
      we = ($urandom % 3 == 0);
      wd = ($urandom % 2 == 0) ? $urandom : (32'($urandom) & IMPL);
      case (a)
        2'd0:    cyc(ix, ms, a, we, wd, "R4 random status");
        2'd1:    cyc(ix, ms, a, we, wd, "R6 random enable");
        default: cyc(ix, ms, a, we, wd, "R9 random unused");
      endcase
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule